// File: doc/BRIEF.md
# Exact Wide Fixed-Point Accumulator for Double-Precision Operands

This block sums double-precision floating-point operands with no rounding at all. Each operand is converted into a signed integer placed inside a very wide two's-complement register whose least significant bit has the weight of the smallest subnormal. The register is wide enough for any finite double plus a few guard bits for carry growth. Because only integer addition is used, the final value is exact and does not depend on the order in which operands arrive.

Operands enter through a valid/ready handshake. The exponent field picks a bit offset, and the significand (with its hidden bit restored for normal numbers) is shifted to that offset. A narrow integer adder then walks the register one slice per clock, starting at the lowest slice the significand touches. It passes the carry (or the borrow, for negative operands) upward and stops as soon as no further slice can change. The register lives in a small RAM of slices, so a clear strobe zeroes it with a sweep of one slice per cycle. The accumulated value is read one slice at a time through an index port. Operands with an all-ones exponent (infinities and NaNs) are not added; they only raise a sticky flag.

Top module: `exact_wide_accum`

## Requirements
- R1: An operand is {sign[OP_W-1], exponent[FRAC_W+EXP_W-1:FRAC_W], fraction[FRAC_W-1:0]}. With exponent E between 1 and 2^EXP_W-2, the value (2^FRAC_W + fraction) is placed at accumulator bit E-1. With E = 0, the value fraction is placed at bit 0.
- R2: A positive operand adds its placed value to the accumulator exactly, modulo 2^ACC_W where ACC_W = (2^EXP_W - 3) + (FRAC_W + 1) + GUARD_W.
- R3: An operand with sign bit 1 subtracts its placed value. The result is in two's complement and extends its sign through the top slice.
- R4: Summing the same set of operands in any order leaves an identical accumulator.
- R5: A carry or borrow propagates across every slice boundary, up to the most significant slice where needed.
- R6: Reset, and a one-cycle clear strobe, set every slice and the invalid flag to zero. Busy stays high while the zeroing sweep runs.
- R7: An operand whose exponent is all ones sets the sticky invalid flag and leaves the accumulator unchanged. It does not make the block busy.
- R8: in_ready is high exactly when busy is low. An operand is taken on a clock edge where in_valid and in_ready are both high, and each accepted operand is added exactly once.
- R9: While the block is not busy, rd_data holds slice rd_idx, sampled at the previous clock edge. Slice 0 holds the least significant SLICE_W bits.
- R10: Positive zero and negative zero leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a zeroing sweep |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand |
| in_op | input | 1+EXP_W+FRAC_W | Floating-point operand (sign, exponent, fraction) |
| clear | input | 1 | Strobe that zeroes the accumulator and the invalid flag |
| busy | output | 1 | Add ripple or zeroing sweep in progress |
| invalid | output | 1 | Sticky flag: an infinity or NaN was offered |
| rd_idx | input | clog2(NSLICE) | Slice index to read |
| rd_data | output | SLICE_W | Registered contents of slice rd_idx |

## Verification
The bench uses a tiny format with a 4-bit exponent, a 3-bit fraction and 4-bit slices, so it can feed every one of the 256 operand codes. It compares the whole register against an integer model after each operand. Subnormals checked next to the smallest normals expose a wrong hidden bit or an offset off by one. Negative zero would corrupt the register if the borrow start were wrong. An all-ones exponent would show up as a changed sum or a missing flag. Adding +1 and -1 across an empty register forces the borrow through every slice; a design that stops its ripple early leaves stale high slices. The full sweep is repeated in reverse order, and an operand is held on the input while the block is busy, to catch a double acceptance.

// File: rtl/ewa_pkg.sv
package ewa_pkg;
  typedef enum logic [1:0] {
    ST_CLR  = 2'd0,
    ST_IDLE = 2'd1,
    ST_ADD  = 2'd2
  } ewa_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/ewa_place.sv
// Splits an operand into sign, special flag, start slice and the
// significand shifted to its position inside that slice window.
module ewa_place #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int SW     = 32,
  parameter int NWIN   = 3,
  parameter int IDX_W  = 7
) (
  input  logic [EXP_W+FRAC_W:0]  op_i,
  output logic                   neg_o,
  output logic                   special_o,
  output logic [IDX_W-1:0]       start_o,
  output logic [NWIN*SW-1:0]     win_o
);
  localparam int OP_W  = 1 + EXP_W + FRAC_W;
  localparam int WIN_W = NWIN * SW;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W:0]   sig;
  logic [EXP_W-1:0]  off;

  assign expo      = op_i[FRAC_W +: EXP_W];
  assign frac      = op_i[FRAC_W-1:0];
  assign neg_o     = op_i[OP_W-1];
  assign special_o = &expo;
  assign sig       = {(expo != '0), frac};
  assign off       = (expo == '0) ? '0 : expo - 1'b1;
  assign start_o   = IDX_W'(int'(off) / SW);
  assign win_o     = WIN_W'(sig) << (int'(off) % SW);

  // R1: the window must be wide enough that no significand bit is lost
  always_comb begin
    p_window_holds_sig_r1: assert ($countones(win_o) == $countones(sig))
      else $error("significand bits lost in placement window");
  end
endmodule

// File: rtl/ewa_slice_add.sv
// One slice of the carry chain: adds or subtracts a slice of the window.
module ewa_slice_add #(
  parameter int SW = 32
) (
  input  logic [SW-1:0] acc_i,
  input  logic [SW-1:0] x_i,
  input  logic          neg_i,
  input  logic          cin_i,
  output logic [SW-1:0] sum_o,
  output logic          cout_o
);
  logic [SW-1:0] addend;
  assign addend = neg_i ? ~x_i : x_i;
  assign {cout_o, sum_o} = {1'b0, acc_i} + {1'b0, addend} + (SW+1)'(cin_i);
endmodule

// File: rtl/ewa_ram.sv
// Slice storage: one write port, one asynchronous read port for the
// carry walk and one registered read port for readout.
module ewa_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 66,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];

  always_ff @(posedge clk) begin
    if (int'(raddr_b) < DEPTH) rdata_b <= mem[raddr_b];
    else                       rdata_b <= '0;
  end
endmodule

// File: rtl/exact_wide_accum.sv
module exact_wide_accum
  import ewa_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int SLICE_W = 32,
  parameter int GUARD_W = 3,
  localparam int OP_W   = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int MAXOFF = (2 ** EXP_W) - 3,
  localparam int ACC_W  = MAXOFF + SIG_W + GUARD_W,
  localparam int NSLICE = ceil_div(ACC_W, SLICE_W),
  localparam int NWIN   = ceil_div(2 * SLICE_W - 2 + SIG_W, SLICE_W),
  localparam int WIN_W  = NWIN * SLICE_W,
  localparam int IDX_W  = $clog2(NSLICE),
  localparam int WCNT_W = $clog2(NWIN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OP_W-1:0]    in_op,
  input  logic               clear,
  output logic               busy,
  output logic               invalid,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [SLICE_W-1:0] rd_data
);
  ewa_state_e          st;
  logic [IDX_W-1:0]    ptr;
  logic [WIN_W-1:0]    win;
  logic [WCNT_W-1:0]   wcnt;
  logic                neg_q, carry_q, invalid_q;

  logic                d_neg, d_special;
  logic [IDX_W-1:0]    d_start;
  logic [WIN_W-1:0]    d_win;
  logic [SLICE_W-1:0]  cur, x, sum, wdata;
  logic                cout, we, last, done_add, accept;

  ewa_place #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .SW(SLICE_W), .NWIN(NWIN), .IDX_W(IDX_W)
  ) i_place (
    .op_i(in_op), .neg_o(d_neg), .special_o(d_special),
    .start_o(d_start), .win_o(d_win)
  );

  assign x = (wcnt != '0) ? win[SLICE_W-1:0] : '0;

  ewa_slice_add #(.SW(SLICE_W)) i_add (
    .acc_i(cur), .x_i(x), .neg_i(neg_q), .cin_i(carry_q),
    .sum_o(sum), .cout_o(cout)
  );

  assign we    = (st == ST_CLR) || (st == ST_ADD);
  assign wdata = (st == ST_CLR) ? '0 : sum;

  ewa_ram #(.DW(SLICE_W), .DEPTH(NSLICE), .AW(IDX_W)) i_ram (
    .clk(clk), .we(we), .waddr(ptr), .wdata(wdata),
    .raddr_a(ptr), .rdata_a(cur), .raddr_b(rd_idx), .rdata_b(rd_data)
  );

  assign last     = (ptr == IDX_W'(NSLICE - 1));
  // beyond the window a slice stays untouched once carry equals the sign
  assign done_add = last || ((wcnt <= WCNT_W'(1)) && (cout == neg_q));
  assign accept   = in_valid && (st == ST_IDLE) && !clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_CLR;
      ptr       <= '0;
      win       <= '0;
      wcnt      <= '0;
      neg_q     <= 1'b0;
      carry_q   <= 1'b0;
      invalid_q <= 1'b0;
    end else if (clear) begin
      st        <= ST_CLR;
      ptr       <= '0;
      invalid_q <= 1'b0;
    end else begin
      case (st)
        ST_CLR: begin
          if (last) st <= ST_IDLE;
          else      ptr <= ptr + 1'b1;
        end
        ST_IDLE: begin
          if (accept) begin
            if (d_special) begin
              invalid_q <= 1'b1;
            end else begin
              st      <= ST_ADD;
              ptr     <= d_start;
              win     <= d_win;
              wcnt    <= WCNT_W'(NWIN);
              neg_q   <= d_neg;
              carry_q <= d_neg;
            end
          end
        end
        ST_ADD: begin
          carry_q <= cout;
          if (done_add) begin
            st <= ST_IDLE;
          end else begin
            ptr <= ptr + 1'b1;
            win <= win >> SLICE_W;
            if (wcnt != '0) wcnt <= wcnt - 1'b1;
          end
        end
        default: st <= ST_CLR;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign in_ready = (st == ST_IDLE);
  assign invalid  = invalid_q;

  // R6: a clear strobe always starts the zeroing sweep
  p_clear_starts_sweep_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> busy);

  // R7: a special operand is flagged and never starts an add
  p_special_skipped_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !clear && (&in_op[FRAC_W +: EXP_W]))
      |=> (!busy && invalid));

  // R7: the invalid flag holds until a clear
  p_invalid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (invalid && !clear) |=> invalid);

  // R5: the carry walk moves up exactly one slice per cycle
  p_ripple_steps_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADD && !clear) |=> (st != ST_ADD || ptr == $past(ptr) + 1'b1));
endmodule

// File: tb/test_exact_wide_accum.sv
module test_exact_wide_accum;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_W  = 4;
  localparam int FRAC_W = 3;
  localparam int SW     = 4;
  localparam int GUARD  = 3;
  localparam int OP_W   = 1 + EXP_W + FRAC_W;
  localparam int ACC_W  = (2 ** EXP_W) - 3 + FRAC_W + 1 + GUARD;
  localparam int NS     = (ACC_W + SW - 1) / SW;
  localparam int IDX_W  = $clog2(NS);

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, clear = 1'b0;
  logic [OP_W-1:0]  in_op = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic in_ready, busy, invalid;
  logic [SW-1:0] rd_data;

  int n_chk = 0, n_err = 0;
  longint model = 0;
  logic [ACC_W-1:0] acc_v, fwd_final;

  always #(CLK_PERIOD/2) clk = ~clk;

  exact_wide_accum #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SLICE_W(SW), .GUARD_W(GUARD))
    i_exact_wide_accum (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .clear(clear), .busy(busy), .invalid(invalid),
      .rd_idx(rd_idx), .rd_data(rd_data));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint op_val(input logic [OP_W-1:0] c);
    longint e, f, m;
    e = longint'(c[FRAC_W +: EXP_W]);
    f = longint'(c[FRAC_W-1:0]);
    if (e == 0) m = f;
    else        m = ((64'd1 << FRAC_W) + f) << (e - 1);
    return c[OP_W-1] ? -m : m;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic read_acc(output logic [ACC_W-1:0] v);
    logic [NS*SW-1:0] t;
    for (int k = 0; k < NS; k++) begin
      rd_idx = IDX_W'(k);
      @(posedge clk);
      @(negedge clk);
      t[k*SW +: SW] = rd_data;
    end
    v = t[ACC_W-1:0];
  endtask

  task automatic send(input logic [OP_W-1:0] c);
    in_op = c;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (busy) @(negedge clk);
    if (!(&c[FRAC_W +: EXP_W])) model = model + op_val(c);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    wait_idle();
    model = 0;
  endtask

  task automatic sweep_check(input logic [OP_W-1:0] c);
    string tag;
    logic [ACC_W-1:0] exp_v;
    if (&c[FRAC_W +: EXP_W])           tag = "R7 special skipped";
    else if (c[OP_W-2:0] == '0)        tag = "R10 signed zero";
    else if (c[OP_W-1])                tag = "R3 negative subtract";
    else if (c[FRAC_W +: EXP_W] == '0) tag = "R1 subnormal place";
    else                               tag = "R2 positive add";
    send(c);
    read_acc(acc_v);
    exp_v = model[ACC_W-1:0];
    chk(tag, longint'(acc_v), longint'(exp_v));
    if (&c[FRAC_W +: EXP_W]) chk("R7 invalid flag set", longint'(invalid), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_idle();
    // reset state
    read_acc(acc_v);
    chk("R6 reset zero", longint'(acc_v), 0);
    chk("R6 reset invalid", longint'(invalid), 0);
    chk("R8 ready after reset", longint'(in_ready), 1);

    // R1 R2 R3 R7 R10: every code in ascending order
    for (int c = 0; c < 256; c++) sweep_check(OP_W'(c));
    fwd_final = model[ACC_W-1:0];

    do_clear();
    read_acc(acc_v);
    chk("R6 clear zero", longint'(acc_v), 0);
    chk("R6 clear invalid", longint'(invalid), 0);

    // R4: same codes in descending order
    for (int c = 255; c >= 0; c--) sweep_check(OP_W'(c));
    read_acc(acc_v);
    chk("R4 order independent", longint'(acc_v), longint'(fwd_final));

    // R5: borrow through every slice and back
    do_clear();
    send(8'h81);
    read_acc(acc_v);
    chk("R5 borrow to top", longint'(acc_v), longint'({ACC_W{1'b1}}));
    rd_idx = IDX_W'(NS - 1);
    @(posedge clk); @(negedge clk);
    chk("R9 top slice sign", longint'(rd_data), longint'({SW{1'b1}}));
    send(8'h01);
    read_acc(acc_v);
    chk("R5 carry clears all", longint'(acc_v), 0);
    send(8'h01);
    rd_idx = '0;
    @(posedge clk); @(negedge clk);
    chk("R9 slice0 lsb", longint'(rd_data), 1);
    rd_idx = IDX_W'(1);
    @(posedge clk); @(negedge clk);
    chk("R9 slice1 empty", longint'(rd_data), 0);

    // R8: second operand held while busy is taken once
    do_clear();
    @(negedge clk);
    in_op = 8'h77;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 busy after accept", longint'(busy), 1);
    chk("R8 not ready while busy", longint'(in_ready), 0);
    in_op = 8'h08;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
    model = op_val(8'h77) + op_val(8'h08);
    read_acc(acc_v);
    chk("R8 each accepted once", longint'(acc_v), longint'(model[ACC_W-1:0]));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule